// File: doc/BRIEF.md
# Serial Command Word Port

This block is a serial slave port for a register-based peripheral. A host drives an active-low chip select, a serial clock and a serial data line. Each command is a 16-bit word: the upper byte is the command address, whose top bit gives the direction, and the lower byte carries the data. All serial inputs pass through synchronizers into the core clock domain, and the word is decoded when chip select returns high. A write produces a one-cycle write strobe that carries the address and the data. A read produces a one-cycle read strobe. The byte returned on `rd_data` in that cycle is placed in the shifter, so the host can clock it out during its next frame.

The serial output always presents the bit that entered the shifter sixteen serial clocks earlier, so several ports can be chained on one select line. Only the last sixteen bits clocked in before chip select rises are decoded. The port also owns an auto-incrementing pointer into a mapping table. A write to one address loads the pointer. Each read of a second address returns the table entry at the pointer and then advances it. The register file, the table storage and everything behind them sit outside this block.

Top module: `spi_cmd_port`

## Requirements
- R1: After reset, `sdo` is 0, `map_ptr` is 0, and neither `wr_stb` nor `rd_stb` is asserted.
- R2: A frame of exactly 16 bits whose first bit (bit 15, sampled MSB first on rising `sclk`) is 0 produces exactly one single-cycle `wr_stb` after `cs_n` rises, with `wr_addr` = bits 14..8 and `wr_data` = bits 7..0, and no `rd_stb`.
- R3: A frame with fewer than 16 rising `sclk` edges produces no strobe of either kind and leaves `map_ptr` unchanged.
- R4: A frame with more than 16 bits is decoded from its last 16 bits only.
- R5: While `cs_n` is low, before each rising `sclk` edge `sdo` shows the bit that entered the shifter 16 rising edges earlier.
- R6: A 16-bit frame whose bit 15 is 1 produces exactly one single-cycle `rd_stb` with `rd_addr` = bits 14..8 and no `wr_stb`. During the next frame, `sdo` shows the 8 command-address bits first and then the byte that was on `rd_data` during the `rd_stb` cycle, MSB first.
- R7: A read of address `MAP_DATA_ADDR` (default 13) returns the table entry at `map_ptr`, after which `map_ptr` advances by one and wraps from 2^PTR_W-1 to 0.
- R8: A write to address `MAP_PTR_ADDR` (default 12) loads `map_ptr` with the low PTR_W bits of the data byte. No other strobe changes `map_ptr`.
- R9: While `cs_n` is high, `sclk` and `sdi` activity changes neither the shifter contents nor the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, data sampled on rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out, 16-bit delayed copy or read data |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| rd_stb | output | 1 | One-cycle read strobe |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | DATA_W | Read byte, valid in the `rd_stb` cycle |
| map_ptr | output | PTR_W | Mapping-table pointer |

## Verification
The hardest case to reach is the pointer wrapping from its top value to zero. It requires a pointer load near the top of the range followed by a run of consecutive table reads. The bench loads the pointer to 60 and issues six table reads. It checks the returned bytes on `sdo` in each following frame and the pointer value after each read. Ignored clock activity while the port is deselected can only be observed indirectly. The bench toggles `sclk` with select high and then shows that the first 16 `sdo` bits of the next frame still match the shifter contents from before the idle toggling.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   typedef enum logic {
      CMD_WRITE = 1'b0,
      CMD_READ  = 1'b1
   } cmd_kind_e;

   localparam int DEF_ADDR_W        = 7;
   localparam int DEF_DATA_W        = 8;
   localparam int DEF_PTR_W         = 6;
   localparam int DEF_SYNC_STAGES   = 2;
   localparam int DEF_MAP_PTR_ADDR  = 12;
   localparam int DEF_MAP_DATA_ADDR = 13;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
   parameter int           W       = 3,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
   parameter int FRAME_W = 16,
   parameter int LOAD_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               din,
   input  logic               frame_end,
   input  logic               load_en,
   input  logic [LOAD_W-1:0]  load_byte,
   output logic [FRAME_W-1:0] word,
   output logic               full,
   output logic               dout
);
   localparam int CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= '0;
      end else if (load_en) begin
         word[LOAD_W-1:0] <= load_byte;
      end else if (shift_en) begin
         word <= {word[FRAME_W-2:0], din};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (frame_end) begin
         cnt <= '0;
      end else if (shift_en && cnt != CNT_MAX) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign full = (cnt == CNT_MAX);
   assign dout = word[FRAME_W-1];
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
   import spi_cmd_pkg::*;
#(
   parameter int ADDR_W        = 7,
   parameter int DATA_W        = 8,
   parameter int PTR_W         = 6,
   parameter int MAP_PTR_ADDR  = 12,
   parameter int MAP_DATA_ADDR = 13,
   localparam int FRAME_W      = 1 + ADDR_W + DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_end,
   input  logic               full,
   input  logic [FRAME_W-1:0] word,
   output logic               wr_stb,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [DATA_W-1:0]  wr_data,
   output logic               rd_stb,
   output logic [ADDR_W-1:0]  rd_addr,
   output logic [PTR_W-1:0]   map_ptr
);
   localparam logic [ADDR_W-1:0] PTR_A  = ADDR_W'(MAP_PTR_ADDR);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(MAP_DATA_ADDR);

   cmd_kind_e               kind;
   logic [ADDR_W-1:0]       addr_f;
   logic [DATA_W-1:0]       data_f;

   assign kind   = cmd_kind_e'(word[FRAME_W-1]);
   assign addr_f = word[FRAME_W-2 -: ADDR_W];
   assign data_f = word[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_stb  <= 1'b0;
         rd_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         rd_addr <= '0;
      end else begin
         wr_stb <= 1'b0;
         rd_stb <= 1'b0;
         if (frame_end && full) begin
            if (kind == CMD_READ) begin
               rd_stb  <= 1'b1;
               rd_addr <= addr_f;
            end else begin
               wr_stb  <= 1'b1;
               wr_addr <= addr_f;
               wr_data <= data_f;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_ptr <= '0;
      end else if (rd_stb && rd_addr == DATA_A) begin
         map_ptr <= map_ptr + 1'b1;
      end else if (wr_stb && wr_addr == PTR_A) begin
         map_ptr <= wr_data[PTR_W-1:0];
      end
   end
endmodule

// File: rtl/spi_cmd_port.sv
module spi_cmd_port
   import spi_cmd_pkg::*;
#(
   parameter int ADDR_W        = DEF_ADDR_W,
   parameter int DATA_W        = DEF_DATA_W,
   parameter int PTR_W         = DEF_PTR_W,
   parameter int SYNC_STAGES   = DEF_SYNC_STAGES,
   parameter int MAP_PTR_ADDR  = DEF_MAP_PTR_ADDR,
   parameter int MAP_DATA_ADDR = DEF_MAP_DATA_ADDR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic              sdo,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_stb,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic [PTR_W-1:0]  map_ptr
);
   localparam int FRAME_W = 1 + ADDR_W + DATA_W;

   generate
      if (PTR_W < 1 || PTR_W > DATA_W) begin : g_bad_ptr
         $error("PTR_W must lie in 1..DATA_W");
      end
      if (MAP_PTR_ADDR >= (1 << ADDR_W) || MAP_DATA_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("mapping addresses exceed the address field");
      end
      if (MAP_PTR_ADDR == MAP_DATA_ADDR) begin : g_same_addr
         $error("mapping pointer and data addresses must differ");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [2:0] raw_in, syn_out;
   logic       cs_s, sclk_s, sdi_s;
   logic       cs_q, sclk_q;
   logic       sclk_rise, frame_end, shift_en;
   logic       full;
   logic [FRAME_W-1:0] word;

   assign raw_in = {cs_n, sclk, sdi};

   spi_cmd_sync #(
      .W      (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(3'b100)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_in),
      .q    (syn_out)
   );

   assign {cs_s, sclk_s, sdi_s} = syn_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         sclk_q <= 1'b0;
      end else begin
         cs_q   <= cs_s;
         sclk_q <= sclk_s;
      end
   end

   assign sclk_rise = sclk_s & ~sclk_q;
   assign frame_end = cs_s & ~cs_q;
   assign shift_en  = sclk_rise & ~cs_s;

   spi_cmd_shifter #(
      .FRAME_W(FRAME_W),
      .LOAD_W (DATA_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .din      (sdi_s),
      .frame_end(frame_end),
      .load_en  (rd_stb),
      .load_byte(rd_data),
      .word     (word),
      .full     (full),
      .dout     (sdo)
   );

   spi_cmd_decode #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .PTR_W        (PTR_W),
      .MAP_PTR_ADDR (MAP_PTR_ADDR),
      .MAP_DATA_ADDR(MAP_DATA_ADDR)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_end(frame_end),
      .full     (full),
      .word     (word),
      .wr_stb   (wr_stb),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_stb   (rd_stb),
      .rd_addr  (rd_addr),
      .map_ptr  (map_ptr)
   );
endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker #(
   parameter int ADDR_W        = 7,
   parameter int DATA_W        = 8,
   parameter int PTR_W         = 6,
   parameter int MAP_PTR_ADDR  = 12,
   parameter int MAP_DATA_ADDR = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_stb,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [PTR_W-1:0]  map_ptr
);
   localparam logic [ADDR_W-1:0] PTR_A  = ADDR_W'(MAP_PTR_ADDR);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(MAP_DATA_ADDR);

   logic map_rd, ptr_wr;
   assign map_rd = rd_stb && rd_addr == DATA_A;
   assign ptr_wr = wr_stb && wr_addr == PTR_A;

   AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(wr_stb && rd_stb)); // R2
   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb); // R2
   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rd_stb |=> !rd_stb); // R6
   AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      map_rd |=> map_ptr == PTR_W'($past(map_ptr) + 1'b1)); // R7
   AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr |=> map_ptr == PTR_W'($past(wr_data))); // R8
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!map_rd && !ptr_wr) |=> $stable(map_ptr)); // R8
endmodule

bind spi_cmd_port spi_cmd_checker #(
   .ADDR_W       (ADDR_W),
   .DATA_W       (DATA_W),
   .PTR_W        (PTR_W),
   .MAP_PTR_ADDR (MAP_PTR_ADDR),
   .MAP_DATA_ADDR(MAP_DATA_ADDR)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_stb (wr_stb),
   .wr_addr(wr_addr),
   .wr_data(wr_data),
   .rd_stb (rd_stb),
   .rd_addr(rd_addr),
   .map_ptr(map_ptr)
);

// File: tb/spi_cmd_port_test.sv
`timescale 1ns/1ps
module spi_cmd_port_test;
   localparam int AW = 7, DW = 8, PW = 6;
   localparam int PTR_A = 12, DATA_A = 13;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic sdo, wr_stb, rd_stb;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [DW-1:0] wr_data, rd_data;
   logic [PW-1:0] map_ptr;

   always #2.5 clk = ~clk;

   spi_cmd_port uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .map_ptr(map_ptr)
   );

   // environment: register file and mapping table
   logic [7:0] env_regs [128];
   logic [7:0] map_tab  [64];
   logic [7:0] exp_regs [128];
   assign rd_data = (rd_addr == AW'(DATA_A)) ? map_tab[map_ptr] : env_regs[rd_addr];

   int wr_cnt = 0, rd_cnt = 0;
   logic [AW-1:0] last_wa, last_ra;
   logic [DW-1:0] last_wd;
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_stb) begin
            wr_cnt++; last_wa = wr_addr; last_wd = wr_data;
            env_regs[wr_addr] = wr_data;
         end
         if (rd_stb) begin
            rd_cnt++; last_ra = rd_addr;
         end
      end
   end

   int checks = 0, failures = 0;
   bit done = 1'b0;
   logic [15:0] model = '0;
   logic [PW-1:0] exp_ptr = '0;
   string dtag = "R5";

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic do_frame(input logic [63:0] bits, input int n);
      int wc0, rc0;
      logic [PW-1:0] p0;
      logic [15:0] w;
      string ftag;
      wc0 = wr_cnt; rc0 = rd_cnt; p0 = map_ptr;
      cs_n = 1'b0;
      repeat (8) @(posedge clk);
      for (int i = 0; i < n; i++) begin
         logic b;
         b = bits[n-1-i];
         sdi = b; sclk = 1'b0;
         repeat (6) @(posedge clk);
         #1;
         chk(sdo == model[15], (i < 16) ? dtag : "R5", "sdo bit", int'(sdo), int'(model[15]));
         sclk = 1'b1;
         model = {model[14:0], b};
         repeat (6) @(posedge clk);
      end
      sclk = 1'b0;
      repeat (6) @(posedge clk);
      cs_n = 1'b1;
      repeat (12) @(posedge clk);
      #1;
      dtag = "R5";
      w = bits[15:0];
      ftag = (n > 16) ? "R4" : "R2";
      if (n < 16) begin
         chk(wr_cnt == wc0 && rd_cnt == rc0, "R3", "strobes on short frame", wr_cnt + rd_cnt, wc0 + rc0);
         chk(map_ptr == p0, "R3", "ptr on short frame", int'(map_ptr), int'(p0));
      end else if (w[15] == 1'b0) begin
         chk(wr_cnt == wc0 + 1 && rd_cnt == rc0, ftag, "write strobe count", wr_cnt - wc0, 1);
         chk(last_wa == w[14:8], ftag, "wr_addr", int'(last_wa), int'(w[14:8]));
         chk(last_wd == w[7:0], ftag, "wr_data", int'(last_wd), int'(w[7:0]));
         exp_regs[w[14:8]] = w[7:0];
         if (int'(w[14:8]) == PTR_A) exp_ptr = w[PW-1:0];
         chk(map_ptr == exp_ptr, "R8", "map_ptr after write", int'(map_ptr), int'(exp_ptr));
      end else begin
         chk(rd_cnt == rc0 + 1 && wr_cnt == wc0, (n > 16) ? "R4" : "R6", "read strobe count", rd_cnt - rc0, 1);
         chk(last_ra == w[14:8], "R6", "rd_addr", int'(last_ra), int'(w[14:8]));
         if (int'(w[14:8]) == DATA_A) begin
            model[7:0] = map_tab[exp_ptr];
            exp_ptr = exp_ptr + 1'b1;
         end else begin
            model[7:0] = exp_regs[w[14:8]];
         end
         chk(map_ptr == exp_ptr, "R7", "map_ptr after read", int'(map_ptr), int'(exp_ptr));
         dtag = "R6";
      end
   endtask

   task automatic wr(input int a, input int d);
      do_frame({48'b0, 1'b0, AW'(a), DW'(d)}, 16);
   endtask

   task automatic rd(input int a);
      do_frame({48'b0, 1'b1, AW'(a), 8'h5A}, 16);
   endtask

   task automatic idle_toggle(input int k);
      int wc0, rc0;
      wc0 = wr_cnt; rc0 = rd_cnt;
      for (int i = 0; i < k; i++) begin
         sdi = i[0]; sclk = 1'b1;
         repeat (6) @(posedge clk);
         sclk = 1'b0;
         repeat (6) @(posedge clk);
      end
      #1;
      chk(wr_cnt == wc0 && rd_cnt == rc0, "R9", "strobes while deselected", wr_cnt + rd_cnt, wc0 + rc0);
      dtag = "R9";
   endtask

   initial begin
      #900us;
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 128; i++) begin env_regs[i] = '0; exp_regs[i] = '0; end
      for (int i = 0; i < 64; i++) map_tab[i] = 8'((i * 37 + 5) & 255);
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #1;
         chk(sdo == 1'b0, "R1", "sdo reset", int'(sdo), 0);
         chk(map_ptr == '0, "R1", "map_ptr reset", int'(map_ptr), 0);
         chk(!wr_stb && !rd_stb, "R1", "strobes reset", int'(wr_stb) + int'(rd_stb), 0);
      end
      // R6 read before any write
      rd(5);
      // R2 sweep writes over every address
      for (int a = 0; a < 128; a++) wr(a, (a * 7 + 3) & 255);
      // R6 / R7 sweep reads over every address
      for (int a = 0; a < 128; a++) rd(a);
      // R7 wrap of the pointer
      wr(PTR_A, 60);
      for (int i = 0; i < 6; i++) rd(DATA_A);
      chk(map_ptr == 6'd2, "R7", "pointer wrapped", int'(map_ptr), 2);
      // R8 pointer load with upper data bits set
      wr(PTR_A, 8'hC7);
      rd(DATA_A);
      // R3 short frames
      do_frame(64'h7F, 7);
      do_frame(64'h1FFF, 15);
      rd(DATA_A);
      // R4 long frames: leading bits discarded
      do_frame({40'b0, 8'hFF, 1'b0, 7'h22, 8'h9C}, 24);
      do_frame({24'b0, 16'hFFFF, 8'h81, 1'b1, 7'h22, 8'h00}, 40);
      // R9 deselected activity
      wr(40, 8'hA5);
      idle_toggle(20);
      rd(40);
      idle_toggle(9);
      do_frame(64'h0, 16);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule